// File: doc/BRIEF.md
# Page Program Buffer with In-Page Wrap

This block receives a page program command on a four-wire serial link (mode 0, MSB first), collects the data bytes into a one-page staging buffer, and then commits them to a small byte-wide storage array once the chip select is released. The command consists of a one-byte opcode, three address bytes, and any number of data bytes. The low address byte gives the first buffer offset. Data that runs past the end of the page wraps to offset 0 of the same page. If more than a page of data arrives, later bytes overwrite earlier ones, so only the last page-worth is kept.

The write-enable latch lives outside the block and is presented as an input. The block raises a one-cycle clear strobe when programming finishes. Programming is self-timed. The block walks every page offset once and writes only the offsets that received data, combining each new byte with the stored byte by bitwise AND. It then holds busy for a parameterised number of extra cycles. A read port on the array lets the surrounding logic see its contents. The array starts out erased, with every byte at FFh.

Top module: `pp_page_program`

## Requirements
- R1: After reset, busy_o, wel_clr_o and arr_we_o are low and every array byte reads FFh.
- R2: A transaction whose first complete byte is 02h, with wel_i high at that byte, is accepted. Any other first byte causes the rest of the transaction to be ignored, and the array is unchanged.
- R3: With wel_i low when the opcode byte completes, the command is ignored: no busy period and no array change.
- R4: Data byte k of an accepted command goes to page offset (A[7:0]+k) mod 256. It wraps within the page selected by address bits [9:8] when there are four pages. For example, a start at offset FEh with three bytes fills FEh, FFh, then 00h.
- R5: When more than 256 data bytes arrive, each offset holds the last byte sent to it.
- R6: Offsets of the page that received no data in the transaction keep their previous contents. Other pages are untouched.
- R7: Programming stores old AND new, so a bit can only go from 1 to 0.
- R8: An accepted command with at least one full data byte raises busy_o within a few cycles of chip select rising. busy_o stays high for exactly 256+BUSY_CYC cycles. wel_clr_o pulses for one cycle, in the last busy cycle.
- R9: Bytes and whole commands sent while busy_o is high are ignored. Bytes left over from such a transaction after busy falls are also ignored.
- R10: If chip select rises before all three address bytes arrive, or before any complete data byte arrives, the command is dropped without a busy period.
- R11: Array writes happen only while busy, at most once per offset, and in ascending offset order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, sampled on its rising edge |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in, MSB first |
| wel_i | input | 1 | Write-enable latch state |
| wel_clr_o | output | 1 | One-cycle request to clear the write-enable latch |
| busy_o | output | 1 | Programming in progress |
| arr_we_o | output | 1 | Array write strobe |
| arr_waddr_o | output | AW | Array write byte address |
| arr_wdata_o | output | 8 | Value written (old AND new) |
| rd_addr_i | input | AW | Array read address |
| rd_data_o | output | 8 | Array read data |

## Verification
The hardest case to reach is a complete, valid command that arrives while a previous page is still programming. Only an idle block would accept it, and it must not leak into the array once busy drops. The bench starts a short program, waits for busy_o to rise, and then clocks out a full opcode, address and data sequence with wel_i high. It then confirms that no second busy period follows and that the target page still matches the bench's own model. Overflow past 256 bytes and an AND over already-programmed bytes are also driven from the vector table.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam logic [7:0] PP_OPCODE = 8'h02;
  localparam int         PP_ADDR_BYTES = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_SKIP,
    ST_PROG,
    ST_WAIT
  } pp_state_e;
endpackage

// File: rtl/pp_spi_rx.sv
module pp_spi_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  output logic [7:0] byte_o,
  output logic       byte_vld_o,
  output logic       cs_rise_o,
  output logic       cs_fall_o
);
  logic [SYNC_STAGES-1:0] sck_s, cs_s, mosi_s;
  logic sck_q, cs_q;
  logic [2:0] bit_cnt_q, bit_cnt_d;
  logic [7:0] shreg_q, shreg_d;
  logic       vld_q, vld_d;

  wire sck_now  = sck_s[SYNC_STAGES-1];
  wire cs_now   = cs_s[SYNC_STAGES-1];
  wire mosi_now = mosi_s[SYNC_STAGES-1];
  wire sck_rise = sck_now & ~sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sck_s  <= {sck_s[SYNC_STAGES-2:0], sck};
      cs_s   <= {cs_s[SYNC_STAGES-2:0], cs_n};
      mosi_s <= {mosi_s[SYNC_STAGES-2:0], mosi};
      sck_q  <= sck_now;
      cs_q   <= cs_now;
    end
  end

  always_comb begin
    bit_cnt_d = bit_cnt_q;
    shreg_d   = shreg_q;
    vld_d     = 1'b0;
    if (cs_now) begin
      bit_cnt_d = '0;
    end else if (sck_rise) begin
      shreg_d   = {shreg_q[6:0], mosi_now};
      bit_cnt_d = bit_cnt_q + 3'd1;
      vld_d     = (bit_cnt_q == 3'd7);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      vld_q     <= 1'b0;
    end else begin
      bit_cnt_q <= bit_cnt_d;
      shreg_q   <= shreg_d;
      vld_q     <= vld_d;
    end
  end

  assign byte_o     = shreg_q;
  assign byte_vld_o = vld_q;
  assign cs_rise_o  = cs_now & ~cs_q;
  assign cs_fall_o  = ~cs_now & cs_q;
endmodule

// File: rtl/pp_page_buf.sv
module pp_page_buf #(
  parameter int PAGE_BYTES = 256,
  localparam int IW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_clr,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic          rd_vld
);
  logic [7:0]            mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q, mask_d;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_comb begin
    mask_d = mask_q;
    if (mask_clr)   mask_d = '0;
    else if (wr_en) mask_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign rd_data = mem[rd_idx];
  assign rd_vld  = mask_q[rd_idx];
endmodule

// File: rtl/pp_array.sv
module pp_array #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] paddr,
  output logic [7:0]    pdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign pdata = mem[paddr];
  assign rdata = mem[raddr];
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int PAGE_BITS  = 2,
  parameter int BUSY_CYC   = 64,
  localparam int IW  = $clog2(PAGE_BYTES),
  localparam int WCW = $clog2(BUSY_CYC + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           rx_byte,
  input  logic                 rx_vld,
  input  logic                 cs_rise,
  input  logic                 cs_fall,
  input  logic                 wel_i,
  output logic                 mask_clr,
  output logic                 buf_wr,
  output logic [IW-1:0]        buf_idx,
  output logic                 prog_act,
  output logic [IW-1:0]        prog_idx,
  output logic [PAGE_BITS-1:0] page,
  output logic                 busy,
  output logic                 wel_clr
);
  localparam logic [IW-1:0]  LAST_IDX = IW'(PAGE_BYTES - 1);
  localparam logic [WCW-1:0] LAST_W   = WCW'(BUSY_CYC - 1);

  pp_state_e            st_q, st_d;
  logic                 first_q, first_d;
  logic [1:0]           acnt_q, acnt_d;
  logic [PAGE_BITS-1:0] page_q, page_d;
  logic [IW-1:0]        idx_q, idx_d;
  logic                 got_q, got_d;
  logic [IW-1:0]        pcnt_q, pcnt_d;
  logic [WCW-1:0]       wcnt_q, wcnt_d;

  always_comb begin
    st_d     = st_q;
    first_d  = first_q;
    acnt_d   = acnt_q;
    page_d   = page_q;
    idx_d    = idx_q;
    got_d    = got_q;
    pcnt_d   = pcnt_q;
    wcnt_d   = wcnt_q;
    mask_clr = 1'b0;
    buf_wr   = 1'b0;
    if (rx_vld)  first_d = 1'b0;
    if (cs_fall) first_d = 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        if (rx_vld && first_q) begin
          if (rx_byte == PP_OPCODE && wel_i) begin
            st_d     = ST_ADDR;
            acnt_d   = '0;
            got_d    = 1'b0;
            mask_clr = 1'b1;
          end else begin
            st_d = ST_SKIP;
          end
        end
      end
      ST_ADDR: begin
        if (cs_rise) begin
          st_d = ST_IDLE;
        end else if (rx_vld) begin
          acnt_d = acnt_q + 2'd1;
          if (acnt_q == 2'd1) page_d = rx_byte[PAGE_BITS-1:0];
          if (acnt_q == 2'(PP_ADDR_BYTES - 1)) begin
            idx_d = rx_byte[IW-1:0];
            st_d  = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (cs_rise) begin
          st_d   = got_q ? ST_PROG : ST_IDLE;
          pcnt_d = '0;
        end else if (rx_vld) begin
          buf_wr = 1'b1;
          idx_d  = idx_q + 1'b1;
          got_d  = 1'b1;
        end
      end
      ST_SKIP: begin
        if (cs_rise) st_d = ST_IDLE;
      end
      ST_PROG: begin
        pcnt_d = pcnt_q + 1'b1;
        if (pcnt_q == LAST_IDX) begin
          st_d   = ST_WAIT;
          wcnt_d = '0;
        end
      end
      ST_WAIT: begin
        wcnt_d = wcnt_q + 1'b1;
        if (wcnt_q == LAST_W) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      first_q <= 1'b0;
      acnt_q  <= '0;
      page_q  <= '0;
      idx_q   <= '0;
      got_q   <= 1'b0;
      pcnt_q  <= '0;
      wcnt_q  <= '0;
    end else begin
      st_q    <= st_d;
      first_q <= first_d;
      acnt_q  <= acnt_d;
      page_q  <= page_d;
      idx_q   <= idx_d;
      got_q   <= got_d;
      pcnt_q  <= pcnt_d;
      wcnt_q  <= wcnt_d;
    end
  end

  assign buf_idx  = idx_q;
  assign prog_act = (st_q == ST_PROG);
  assign prog_idx = pcnt_q;
  assign page     = page_q;
  assign busy     = (st_q == ST_PROG) || (st_q == ST_WAIT);
  assign wel_clr  = (st_q == ST_WAIT) && (wcnt_q == LAST_W);
endmodule

// File: rtl/pp_page_program.sv
module pp_page_program #(
  parameter int PAGE_BYTES = 256,
  parameter int ARR_PAGES  = 4,
  parameter int BUSY_CYC   = 64,
  localparam int IW = $clog2(PAGE_BYTES),
  localparam int PB = $clog2(ARR_PAGES),
  localparam int AW = PB + IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  input  logic          wel_i,
  output logic          wel_clr_o,
  output logic          busy_o,
  output logic          arr_we_o,
  output logic [AW-1:0] arr_waddr_o,
  output logic [7:0]    arr_wdata_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0]    rx_byte;
  logic          rx_vld, cs_rise, cs_fall;
  logic          mask_clr, buf_wr, prog_act;
  logic [IW-1:0] buf_idx, prog_idx;
  logic [PB-1:0] page;
  logic [7:0]    buf_data, arr_old;
  logic          buf_vld;

  pp_spi_rx #(.SYNC_STAGES(2)) u_rx (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .byte_o(rx_byte), .byte_vld_o(rx_vld), .cs_rise_o(cs_rise), .cs_fall_o(cs_fall)
  );

  pp_ctrl #(.PAGE_BYTES(PAGE_BYTES), .PAGE_BITS(PB), .BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_vld(rx_vld),
    .cs_rise(cs_rise), .cs_fall(cs_fall), .wel_i(wel_i),
    .mask_clr(mask_clr), .buf_wr(buf_wr), .buf_idx(buf_idx),
    .prog_act(prog_act), .prog_idx(prog_idx), .page(page),
    .busy(busy_o), .wel_clr(wel_clr_o)
  );

  pp_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .mask_clr(mask_clr), .wr_en(buf_wr),
    .wr_idx(buf_idx), .wr_data(rx_byte), .rd_idx(prog_idx),
    .rd_data(buf_data), .rd_vld(buf_vld)
  );

  assign arr_we_o    = prog_act & buf_vld;
  assign arr_waddr_o = {page, prog_idx};
  assign arr_wdata_o = buf_data & arr_old;

  pp_array #(.DEPTH(ARR_PAGES * PAGE_BYTES)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(arr_we_o), .waddr(arr_waddr_o),
    .wdata(arr_wdata_o), .paddr(arr_waddr_o), .pdata(arr_old),
    .raddr(rd_addr_i), .rdata(rd_data_o)
  );
endmodule

// File: rtl/pp_page_program_chk.sv
module pp_page_program_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          wel_clr_o,
  input logic          arr_we_o,
  input logic [AW-1:0] arr_waddr_o,
  input logic [7:0]    arr_wdata_o,
  input logic [7:0]    old_i
);
  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> busy_o); // R11
  AST_WE_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we_o && $past(arr_we_o)) |-> (arr_waddr_o[7:0] > $past(arr_waddr_o[7:0]))); // R11
  AST_CLR_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr_o |-> busy_o); // R8
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr_o |=> (!wel_clr_o && !busy_o)); // R8
  AST_FALL_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(wel_clr_o)); // R8
  AST_ONLY_CLEARS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> ((arr_wdata_o & ~old_i) == 8'h00)); // R7
endmodule

bind pp_page_program pp_page_program_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .wel_clr_o(wel_clr_o),
  .arr_we_o(arr_we_o), .arr_waddr_o(arr_waddr_o), .arr_wdata_o(arr_wdata_o),
  .old_i(arr_old)
);

// File: tb/pp_page_program_tb.sv
module pp_page_program_tb;
  localparam int BUSY = 400;
  localparam int AW = 10;
  localparam int DEPTH = 1024;

  typedef struct packed {
    logic        wel;
    logic [7:0]  op;
    logic [23:0] addr;
    logic [15:0] n;
    logic [7:0]  seed;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 8'h02, 24'h000010, 16'd4,   8'h11},  // R2 R4 basic
    '{1'b1, 8'h02, 24'h0000FE, 16'd3,   8'hA0},  // R4 wrap
    '{1'b0, 8'h02, 24'h000100, 16'd8,   8'h33},  // R3 no latch
    '{1'b1, 8'h03, 24'h000100, 16'd8,   8'h44},  // R2 wrong opcode
    '{1'b1, 8'h02, 24'h000220, 16'd300, 8'h00},  // R5 overflow
    '{1'b1, 8'h02, 24'h000010, 16'd4,   8'hF0},  // R7 AND
    '{1'b1, 8'h02, 24'h0003C0, 16'd256, 8'h5A},  // R6 full page
    '{1'b1, 8'h02, 24'h7FFF80, 16'd1,   8'h00}   // R4 high address bits
  };

  logic clk, rst_n, sck, cs_n, mosi, wel;
  logic wel_clr, busy, arr_we;
  logic [AW-1:0] waddr, rd_addr;
  logic [7:0] wdata, rd_data;

  int total, bad;
  logic [7:0] shadow [DEPTH];

  pp_page_program #(.BUSY_CYC(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .wel_i(wel), .wel_clr_o(wel_clr), .busy_o(busy), .arr_we_o(arr_we),
    .arr_waddr_o(waddr), .arr_wdata_o(wdata), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = b[i];
      wait_clk(4);
      sck = 1'b1;
      wait_clk(4);
      sck = 1'b0;
    end
  endtask

  task automatic txn(input logic w, input logic [7:0] op, input logic [23:0] a,
                     input int n_addr, input int n_data, input logic [7:0] seed,
                     input int tail_bits);
    wel = w;
    cs_n = 1'b0;
    wait_clk(4);
    send_bits(op, 8);
    for (int i = 0; i < n_addr; i++) send_bits(a[23-8*i -: 8], 8);
    for (int i = 0; i < n_data; i++) send_bits(seed + 8'(i), 8);
    if (tail_bits > 0) send_bits(8'h00, tail_bits);
    wait_clk(4);
    cs_n = 1'b1;
  endtask

  task automatic model(input logic [23:0] a, input int n, input logic [7:0] seed);
    logic [7:0] bufm [256];
    logic [255:0] vm;
    logic [7:0] off;
    vm = '0;
    off = a[7:0];
    for (int i = 0; i < n; i++) begin
      bufm[off] = seed + 8'(i);
      vm[off] = 1'b1;
      off = off + 8'd1;
    end
    for (int i = 0; i < 256; i++)
      if (vm[i]) shadow[{a[9:8], 8'(i)}] = shadow[{a[9:8], 8'(i)}] & bufm[i];
  endtask

  task automatic measure(output logic seen, output int dur, output int clrs);
    seen = 1'b0; dur = 0; clrs = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (busy) seen = 1'b1;
    end
    while (busy) begin
      dur++;
      if (wel_clr) clrs++;
      @(negedge clk);
    end
  endtask

  task automatic check_mem(input string req);
    int mism, first;
    logic [7:0] got;
    mism = 0; first = -1; got = 8'h00;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a);
      #1;
      if (rd_data !== shadow[a]) begin
        if (first < 0) begin first = a; got = rd_data; end
        mism++;
      end
    end
    if (first < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, {first, got}, {first, shadow[first]});
    @(negedge clk);
  endtask

  initial begin
    #1500000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic seen;
    int dur, clrs;
    total = 0; bad = 0;
    sck = 0; cs_n = 1; mosi = 0; wel = 0; rd_addr = '0; rst_n = 0;
    for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
    wait_clk(5);
    rst_n = 1;
    wait_clk(2);
    // R1 reset state
    check(!busy && !wel_clr && !arr_we, "R1 outputs idle", {busy, wel_clr, arr_we}, 0);
    check_mem("R1 erased array");

    // Table of vectors
    foreach (VECS[k]) begin
      logic acc;
      acc = VECS[k].wel && VECS[k].op == 8'h02;
      txn(VECS[k].wel, VECS[k].op, VECS[k].addr, 3, int'(VECS[k].n), VECS[k].seed, 0);
      measure(seen, dur, clrs);
      check(seen == acc, "R2 R3 busy on accept", seen, acc);
      if (acc) begin
        check(dur == 256 + BUSY, "R8 busy length", dur, 256 + BUSY);
        check(clrs == 1, "R8 clear pulse", clrs, 1);
        model(VECS[k].addr, int'(VECS[k].n), VECS[k].seed);
      end
      check_mem("R4 R5 R6 R7 array contents");
    end

    // R10 abort: only two address bytes
    txn(1'b1, 8'h02, 24'h000150, 2, 0, 8'h00, 0);
    measure(seen, dur, clrs);
    check(!seen, "R10 short address", seen, 0);
    // R10 abort: address complete, only a partial data byte
    txn(1'b1, 8'h02, 24'h000150, 3, 0, 8'h00, 5);
    measure(seen, dur, clrs);
    check(!seen, "R10 no data byte", seen, 0);
    check_mem("R10 array unchanged");

    // R9 full command while busy
    txn(1'b1, 8'h02, 24'h000160, 3, 2, 8'h0F, 0);
    model(24'h000160, 2, 8'h0F);
    seen = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin @(negedge clk); if (busy) seen = 1'b1; end
    check(seen, "R8 busy rises", seen, 1);
    txn(1'b1, 8'h02, 24'h000040, 3, 2, 8'h00, 0);
    check(busy, "R9 still busy after second command", busy, 1);
    while (busy) @(negedge clk);
    measure(seen, dur, clrs);
    check(!seen, "R9 no second busy", seen, 0);
    check_mem("R9 busy command ignored");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule